// File: doc/BRIEF.md
# Stacked-Board Command Decoder

This block is the host-facing front end of one board in a stack of waveform generator boards that share a single byte stream. Every board sees every byte. The first byte of a packet is a command. It names a target board, or all boards, and chooses either a register access or a channel-memory access, and either a read or a write. The board whose strapped identity matches the command acts on the packet. Every other board lets the rest of the packet pass without effect.

Three 8-bit registers sit behind the decoder: configuration, checksum and frame select. A memory write turns the remaining bytes of the packet into a burst of 16-bit word writes at consecutive addresses. The checksum register is a CRC-8 that every board updates on every byte it receives, so the host can confirm that the stack saw the intended stream. The decoder also forms the effective trigger and drives an auxiliary pin that carries either the serial read-back line or a masked OR of the channel aux flags.

A byte-valid strobe delivers each byte. An end-of-packet pulse returns the decoder to waiting for a command byte.

Top module: `stack_cmd_decoder`

## Requirements
- R1: Command byte fields are: bits 1:0 target address, bit 2 memory select (1 = memory, 0 = register), bits 6:3 board number, and bit 7 write (1) or read (0). A board acts on the packet only when the board number equals `board_id` or equals 15 (broadcast). When the board number does not match, the packet changes no register and produces no memory write.
- R2: A register write is the command byte followed by one data byte. Address 0 is configuration, address 1 is checksum and address 2 is frame select (`frame_sel`). A write to address 3 changes nothing.
- R3: Configuration bit 1 drives `cfg_clk2x` and bit 2 drives `cfg_enable`.
- R4: Configuration bit 0 drives `cfg_reset`. It is high for exactly one cycle after the write and then clears itself. The other configuration bits and the other registers keep their values.
- R5: `trigger_out` is configuration bit 3 ORed with `hw_trigger`.
- R6: A memory write to memory 0, 1 or 2 is the command byte, then a 16-bit start address sent low byte first, then 16-bit words sent low byte first. Each word produces one `mem_we` pulse, carrying `mem_sel` equal to the memory number and the current address. The address then steps up by one. Memory number 3 produces no writes.
- R7: A matching register read produces `rsp_valid` for one cycle, in the cycle after the command byte. `rsp_byte` carries the value the register held before that byte arrived (address 3 reads 0). A non-matching read produces no response. A memory read produces no response.
- R8: The checksum is a CRC-8 with polynomial x^8+x^2+x+1. It processes each byte MSB first, with zero initial value and no complement, and is updated with every received byte, including bytes addressed to other boards. A matching write to register 1 loads its data byte in place of that update.
- R9: `aux_out` follows `miso` when configuration bit 4 is 1. Otherwise it is 1 exactly when `chan_aux` ANDed with configuration bits 7:5 is nonzero.
- R10: `rx_eop` makes the next received byte a command byte, whatever state the packet had reached. A byte arriving together with `rx_eop` is still processed.
- R11: After reset, all three registers are 0 and `rsp_valid` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id | input | 4 | Strapped identity of this board (0 to 14) |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End of packet |
| hw_trigger | input | 1 | Hardware trigger input |
| miso | input | 1 | Serial read-back line for the aux pin |
| chan_aux | input | 3 | Aux flags from the three channels |
| rsp_valid | output | 1 | Read response strobe |
| rsp_byte | output | 8 | Read response data |
| mem_we | output | 1 | Channel memory word write strobe |
| mem_sel | output | 2 | Target channel memory |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Word data |
| cfg_reset | output | 1 | One-cycle board reset pulse |
| cfg_clk2x | output | 1 | Clock doubler enable |
| cfg_enable | output | 1 | Waveform execution enable |
| trigger_out | output | 1 | Effective trigger |
| frame_sel | output | 8 | Frame select register |
| aux_out | output | 1 | Auxiliary pin |

## Verification
The bench first targets board matching. It writes with a foreign board number and checks that nothing moved, then writes with the broadcast number and checks that it landed. A decoder that only compared board numbers would ignore the broadcast; one that ignored the board number would corrupt registers meant for neighbouring boards. It then checks the checksum against the standard nine-digit test string sent as foreign traffic. A CRC that skipped unaddressed bytes, or that fed bits LSB first, returns a value other than 0xF4. Read responses must carry the pre-update value, so a design that reported the checksum after folding in the read command would fail. Aborting a memory packet with end-of-packet after the address byte checks recovery: a decoder that kept its state would treat the next command as an address byte. Long random traffic then covers the reset pulse width, memory address stepping and the aux mux against the reference model on every cycle.

// File: rtl/stack_cmd_decoder.sv
module stack_cmd_decoder #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    board_id,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eop,
  input  logic          hw_trigger,
  input  logic          miso,
  input  logic [2:0]    chan_aux,
  output logic          rsp_valid,
  output logic [7:0]    rsp_byte,
  output logic          mem_we,
  output logic [1:0]    mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          cfg_reset,
  output logic          cfg_clk2x,
  output logic          cfg_enable,
  output logic          trigger_out,
  output logic [7:0]    frame_sel,
  output logic          aux_out
);
  localparam logic [3:0] BCAST = 4'hF;
  localparam logic [7:0] POLY  = 8'h07;

  typedef enum logic [2:0] {S_CMD, S_REG, S_ALO, S_AHI, S_DLO, S_DHI, S_SKIP} st_t;

  st_t st;
  logic [7:0]    cmd, cfg, crc, frame, lo;
  logic [AW-1:0] ptr;
  logic [7:0]    rd;

  function automatic logic [7:0] crc_step(input logic [7:0] v);
    logic [7:0] c;
    c = v;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ POLY) : (c << 1);
    return c;
  endfunction

  wire hit = (rx_byte[6:3] == BCAST) || (rx_byte[6:3] == board_id);
  wire crc_load = (st == S_REG) && (cmd[1:0] == 2'd1);

  always_comb begin
    case (rx_byte[1:0])
      2'd0:    rd = cfg;
      2'd1:    rd = crc;
      2'd2:    rd = frame;
      default: rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; cmd <= '0; cfg <= '0; crc <= '0; frame <= '0; lo <= '0;
      ptr <= '0; rsp_valid <= 1'b0; rsp_byte <= '0;
      mem_we <= 1'b0; mem_sel <= '0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_we    <= 1'b0;
      cfg[0]    <= 1'b0;
      if (rx_valid) begin
        crc <= crc_load ? rx_byte : crc_step(crc ^ rx_byte);
        case (st)
          S_CMD: begin
            cmd <= rx_byte;
            if (!hit) st <= S_SKIP;
            else if (!rx_byte[7]) begin
              st <= S_SKIP;
              if (!rx_byte[2]) begin
                rsp_valid <= 1'b1;
                rsp_byte  <= rd;
              end
            end else if (rx_byte[2]) st <= (rx_byte[1:0] == 2'd3) ? S_SKIP : S_ALO;
            else st <= S_REG;
          end
          S_REG: begin
            if (cmd[1:0] == 2'd0) cfg <= rx_byte;
            if (cmd[1:0] == 2'd2) frame <= rx_byte;
            st <= S_SKIP;
          end
          S_ALO: begin ptr <= AW'(rx_byte); st <= S_AHI; end
          S_AHI: begin ptr <= AW'({rx_byte, ptr[7:0]}); st <= S_DLO; end
          S_DLO: begin lo <= rx_byte; st <= S_DHI; end
          S_DHI: begin
            mem_we    <= 1'b1;
            mem_sel   <= cmd[1:0];
            mem_addr  <= ptr;
            mem_wdata <= {rx_byte, lo};
            ptr       <= ptr + 1'b1;
            st        <= S_DLO;
          end
          default: st <= S_SKIP;
        endcase
      end
      if (rx_eop) st <= S_CMD;
    end
  end

  assign cfg_reset   = cfg[0];
  assign cfg_clk2x   = cfg[1];
  assign cfg_enable  = cfg[2];
  assign trigger_out = cfg[3] | hw_trigger;
  assign frame_sel   = frame;
  assign aux_out     = cfg[4] ? miso : |(chan_aux & cfg[7:5]);

  assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !cfg_reset);
  assert_rsp_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rx_valid));
  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_we_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid));
  assert_we_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_sel != 2'd3);
  assert_crc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(crc));
  assert_eop_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |=> st == S_CMD);
  assert_frame_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(frame_sel));
endmodule

// File: tb/stack_cmd_decoder_test.sv
module stack_cmd_decoder_test;
  localparam int AW = 16;
  localparam logic [3:0] ID = 4'd5;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_eop = 0, hw_trigger = 0, miso = 0;
  logic [7:0] rx_byte = 0;
  logic [2:0] chan_aux = 0;
  logic rsp_valid, mem_we, cfg_reset, cfg_clk2x, cfg_enable, trigger_out, aux_out;
  logic [7:0] rsp_byte, frame_sel;
  logic [1:0] mem_sel;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int wr_cnt = 0;
  logic [15:0] last_addr, last_data;
  logic [1:0] last_sel;

  always #10 clk = ~clk;

  stack_cmd_decoder #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .board_id(ID), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .hw_trigger(hw_trigger), .miso(miso), .chan_aux(chan_aux),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cfg_reset(cfg_reset),
    .cfg_clk2x(cfg_clk2x), .cfg_enable(cfg_enable), .trigger_out(trigger_out),
    .frame_sel(frame_sel), .aux_out(aux_out));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: byte index within packet
  int idx = 0;
  bit mine = 0;
  logic [7:0] m_cmd = 0, m_cfg = 0, m_crc = 0, m_frame = 0, m_lo = 0;
  int m_ptr = 0;
  bit e_rv = 0, e_we = 0;
  logic [7:0] e_rsp = 0;
  logic [1:0] e_sel = 0;
  int e_addr = 0, e_data = 0;

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ b[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      idx = 0; mine = 0; m_cmd = 0; m_cfg = 0; m_crc = 0; m_frame = 0; m_ptr = 0;
      e_rv = 0; e_we = 0;
    end else begin
      e_rv = 0; e_we = 0;
      if (rx_valid) begin
        logic [7:0] b;
        bit load;
        b = rx_byte; load = 0;
        if (idx == 0) begin
          m_cmd = b;
          mine = (b[6:3] == 4'hF) || (b[6:3] == ID);
          if (mine && !b[7] && !b[2]) begin
            e_rv = 1;
            e_rsp = (b[1:0] == 0) ? m_cfg : (b[1:0] == 1) ? m_crc :
                    (b[1:0] == 2) ? m_frame : 8'h00;
          end
        end
        m_cfg[0] = 0;
        if (idx > 0 && mine && m_cmd[7]) begin
          if (!m_cmd[2]) begin
            if (idx == 1) begin
              if (m_cmd[1:0] == 0) m_cfg = b;
              if (m_cmd[1:0] == 2) m_frame = b;
              if (m_cmd[1:0] == 1) load = 1;
            end
          end else if (m_cmd[1:0] != 3) begin
            if (idx == 1) m_ptr = b;
            else if (idx == 2) m_ptr = m_ptr + b * 256;
            else if ((idx - 3) % 2 == 0) m_lo = b;
            else begin
              e_we = 1; e_sel = m_cmd[1:0]; e_addr = m_ptr % 65536;
              e_data = b * 256 + m_lo; m_ptr = m_ptr + 1;
            end
          end
        end
        m_crc = load ? b : ref_crc(m_crc, b);
        idx++;
      end else m_cfg[0] = 0;
      if (rx_eop) idx = 0;
    end
  end

  always begin
    @(posedge clk); #5;
    if (rst_n) begin
      chk(rsp_valid, e_rv, "R7 rsp_valid");
      if (e_rv) chk(rsp_byte, e_rsp, "R7 rsp_byte");
      chk(mem_we, e_we, "R6 mem_we");
      if (e_we) begin
        chk(mem_sel, e_sel, "R6 mem_sel");
        chk(mem_addr, e_addr, "R6 mem_addr");
        chk(mem_wdata, e_data, "R6 mem_wdata");
      end
      if (mem_we) begin
        wr_cnt++; last_addr = mem_addr; last_data = mem_wdata; last_sel = mem_sel;
      end
      chk(cfg_reset, m_cfg[0], "R4 cfg_reset");
      chk(cfg_clk2x, m_cfg[1], "R3 cfg_clk2x");
      chk(cfg_enable, m_cfg[2], "R3 cfg_enable");
      chk(frame_sel, m_frame, "R2 frame_sel");
      chk(trigger_out, m_cfg[3] | hw_trigger, "R5 trigger_out");
      chk(aux_out, m_cfg[4] ? miso : |(chan_aux & m_cfg[7:5]), "R9 aux_out");
    end
  end

  task automatic send(input logic [7:0] b, input bit e);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_eop = e;
  endtask
  task automatic idle();
    @(negedge clk); rx_valid = 0; rx_eop = 0;
  endtask
  task automatic read_reg(input logic [7:0] c, input logic [7:0] exp, input string tag);
    send(c, 1); idle();
    chk(rsp_valid, 1, tag); chk(rsp_byte, exp, tag);
  endtask
  task automatic no_rsp(input logic [7:0] c, input string tag);
    send(c, 1); idle(); chk(rsp_valid, 0, tag);
  endtask

  string digits = "123456789";

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(frame_sel, 0, "R11 frame"); chk(cfg_enable, 0, "R11 enable");
    chk(rsp_valid, 0, "R11 rsp"); chk(mem_we, 0, "R11 we");
    read_reg(8'h29, 8'h00, "R11 crc");
    // R1 match, mismatch, broadcast
    send(8'hAA, 0); send(8'h5C, 1); idle(); chk(frame_sel, 8'h5C, "R1 own board");
    read_reg(8'h2A, 8'h5C, "R1 read frame");
    send(8'hA2, 0); send(8'h11, 1); idle(); chk(frame_sel, 8'h5C, "R1 other board");
    send(8'hFA, 0); send(8'h33, 1); idle(); chk(frame_sel, 8'h33, "R1 broadcast");
    // R2 address 3 ignored
    send(8'hAB, 0); send(8'h77, 1); idle();
    chk(frame_sel, 8'h33, "R2 addr3"); read_reg(8'h28, 8'h00, "R2 addr3 cfg");
    // R4 reset pulse
    send(8'hF8, 0); send(8'h07, 1); idle();
    chk(cfg_reset, 1, "R4 pulse"); chk(cfg_enable, 1, "R3 enable");
    idle();
    chk(cfg_reset, 0, "R4 selfclear"); chk(cfg_clk2x, 1, "R3 clk2x");
    chk(frame_sel, 8'h33, "R4 frame kept");
    read_reg(8'h28, 8'h06, "R7 cfg read");
    // R5 trigger
    send(8'hF8, 0); send(8'h0C, 1); idle(); chk(trigger_out, 1, "R5 soft");
    send(8'hF8, 0); send(8'h04, 1); idle(); chk(trigger_out, 0, "R5 none");
    hw_trigger = 1; #1 chk(trigger_out, 1, "R5 hw");
    @(negedge clk); hw_trigger = 0;
    // R9 aux mux
    send(8'hF8, 0); send(8'hA4, 1); idle();
    chan_aux = 3'b010; #1 chk(aux_out, 0, "R9 masked");
    chan_aux = 3'b100; #1 chk(aux_out, 1, "R9 ch2");
    chan_aux = 3'b001; #1 chk(aux_out, 1, "R9 ch0");
    send(8'hF8, 0); send(8'hB4, 1); idle();
    miso = 0; #1 chk(aux_out, 0, "R9 miso0");
    miso = 1; #1 chk(aux_out, 1, "R9 miso1");
    chan_aux = 0; miso = 0;
    // R6 memory burst
    send(8'hAD, 0); send(8'h02, 0); send(8'h01, 0);
    send(8'hEF, 0); send(8'hBE, 0); send(8'h34, 0); send(8'h12, 1); idle(); idle();
    chk(wr_cnt, 2, "R6 count"); chk(last_addr, 16'h0103, "R6 last addr");
    chk(last_data, 16'h1234, "R6 last data"); chk(last_sel, 1, "R6 sel");
    send(8'hAF, 0); send(8'h00, 0); send(8'h00, 0); send(8'h11, 0); send(8'h22, 1);
    idle(); idle(); chk(wr_cnt, 2, "R6 mem3 ignored");
    // R7 no response cases
    no_rsp(8'h22, "R7 other board");
    no_rsp(8'h2C, "R7 memory read");
    // R8 CRC check value
    send(8'hF9, 0); send(8'h00, 1);
    for (int i = 0; i < 9; i++) send(digits[i], i == 8);
    idle();
    read_reg(8'h29, 8'hF4, "R8 check value");
    send(8'hF9, 0); send(8'h5A, 1); idle();
    read_reg(8'h29, 8'h5A, "R8 load");
    // R10 abort
    send(8'hAD, 0); send(8'h10, 1);
    send(8'hAA, 0); send(8'h42, 1); idle(); idle();
    chk(frame_sel, 8'h42, "R10 recover"); chk(wr_cnt, 2, "R10 no write");
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rx_valid = ($urandom % 4) != 0;
      rx_byte = $urandom;
      if (($urandom % 2) == 0) rx_byte[6:3] = ($urandom % 2) ? ID : 4'hF;
      rx_eop = ($urandom % 9) == 0;
      hw_trigger = $urandom; miso = $urandom; chan_aux = $urandom;
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule